// File: doc/BRIEF.md
# Dual-Channel PWM Action Qualifier

This block turns the event strobes of a shared up-counting time base into two PWM levels, A and B. A qualifying tick marks each time-base step. During that step any mix of four strobes may be set: counter at zero, counter at period, counter at compare A while counting up, and counter at compare B while counting up. Each channel has its own action table. The table gives every event a 2-bit action: keep the level, drive it low, drive it high or invert it. When several events coincide, one fixed priority decides which action wins.

Software may also pin either output to a level through a force register. The force register is a shadow copy. A reload-mode field decides when the shadow becomes the copy that is in effect: at a zero tick, at a period tick, at either of them, or continuously. While a force is in effect it overrides the action table. When it is released, the output keeps its level until the next action. Configuration goes through a simple single-cycle write port with a combinational read path. These are control pins, so there is no handshake.

Top module: `pwm_action_qual`

## Requirements
- R1: After reset both outputs are low and all four registers read as zero.
- R2: Register map, one write per cycle when `bus_wr` is high, read data combinational on `bus_addr`. Address 0 is the table for A and address 1 the table for B. Each table holds zero-event action [1:0], period action [3:2], compare-A action [5:4] and compare-B action [9:8]. Address 2 holds the reload mode in [7:6]. Address 3 holds the force shadow, channel A in [1:0] and channel B in [3:2]. Bits outside these fields read as zero.
- R3: An output changes only on a clock edge where `tb_tick` is high, and the new level is visible after that edge.
- R4: Action codes are 00 keep, 01 low, 10 high and 11 invert the present level.
- R5: Coinciding events resolve in the order compare B, compare A, period, zero. The highest-priority asserted event whose action is not 00 decides, and asserted events with action 00 are passed over.
- R6: Event strobes have no effect while `tb_tick` is low.
- R7: Force codes are 01 force low, 10 force high, and 00 or 11 no force. A force in effect sets the output on each tick, whatever the table says.
- R8: In reload mode 00 the shadow becomes effective on a tick that carries the zero event, and it already governs the output of that tick.
- R9: In reload mode 01 the shadow becomes effective on a tick that carries the period event, and it governs that tick.
- R10: In reload mode 10 the shadow becomes effective on a tick that carries zero or period.
- R11: In reload mode 11 a written force takes effect on the first tick after the write. The output does not move before that tick.
- R12: After a force is released, the output holds its last level until a table action changes it.
- R13: With A's table set to high at zero, high at period and low at compare A, and B's table set to low at zero, low at period and high at compare B, a counting time base yields a normal PWM on A and an inverted one on B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tb_tick | input | 1 | Time-base step qualifier |
| ev_zero | input | 1 | Counter equals zero |
| ev_period | input | 1 | Counter equals period |
| ev_cmpa_up | input | 1 | Counter equals compare A, counting up |
| ev_cmpb_up | input | 1 | Counter equals compare B, counting up |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| pwm_a | output | 1 | Channel A level |
| pwm_b | output | 1 | Channel B level |

## Verification
The embedded properties assume that strobes matter only together with `tb_tick`, and that a register write lands at the edge where `bus_wr` is high. They place no limit on how events combine. The directed phases drive the strobes from a counter model, so zero, period and the compares arrive as a real time base would produce them. The random phase then deliberately sets several strobes at once, writes registers during ticks and changes the reload mode mid-run. This exercises the priority order and the cases where a reload and a write fall in the same cycle.

// File: rtl/pwmaq_pkg.sv
package pwmaq_pkg;

  localparam int NUM_CH  = 2;
  localparam int NUM_EVT = 4;

  // field positions that the bus map exposes
  localparam int F_ZERO = 0;
  localparam int F_PRD  = 2;
  localparam int F_CMPA = 4;
  localparam int F_CMPB = 8;
  localparam int F_MODE = 6;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_INVERT = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    RLD_ZERO   = 2'b00,
    RLD_PERIOD = 2'b01,
    RLD_EITHER = 2'b10,
    RLD_NOW    = 2'b11
  } rld_e;

  // bit 0 lowest priority, top bit highest
  typedef struct packed {
    logic cmpb_up;
    logic cmpa_up;
    logic period;
    logic zero;
  } evt_t;

  typedef struct packed {
    act_e cmpb_up;
    act_e cmpa_up;
    act_e period;
    act_e zero;
  } act_tbl_t;

endpackage

// File: rtl/pwmaq_regs.sv
module pwmaq_regs
  import pwmaq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output act_tbl_t [NUM_CH-1:0]    tbl_o,
  output rld_e                     mode_o,
  output logic [2*NUM_CH-1:0]      frc_shadow_o
);

  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NUM_CH);
  localparam logic [ADDR_W-1:0] FRC_ADDR  = ADDR_W'(NUM_CH + 1);
  localparam logic [DATA_W-1:0] TBL_MASK  = DATA_W'((3 << F_CMPB) | (3 << F_CMPA) |
                                                    (3 << F_PRD) | (3 << F_ZERO));
  localparam logic [DATA_W-1:0] MODE_MASK = DATA_W'(3 << F_MODE);
  localparam logic [DATA_W-1:0] FRC_MASK  = DATA_W'((1 << (2 * NUM_CH)) - 1);

  logic [DATA_W-1:0] tbl_q [NUM_CH];
  logic [DATA_W-1:0] mode_q;
  logic [DATA_W-1:0] frc_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_tbl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tbl_q[ch] <= '0;
      else if (bus_wr && bus_addr == ADDR_W'(ch))
        tbl_q[ch] <= bus_wdata & TBL_MASK;
    end

    assign tbl_o[ch].zero    = act_e'(tbl_q[ch][F_ZERO +: 2]);
    assign tbl_o[ch].period  = act_e'(tbl_q[ch][F_PRD  +: 2]);
    assign tbl_o[ch].cmpa_up = act_e'(tbl_q[ch][F_CMPA +: 2]);
    assign tbl_o[ch].cmpb_up = act_e'(tbl_q[ch][F_CMPB +: 2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      frc_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == MODE_ADDR) mode_q <= bus_wdata & MODE_MASK;
      if (bus_addr == FRC_ADDR)  frc_q  <= bus_wdata & FRC_MASK;
    end
  end

  assign mode_o       = rld_e'(mode_q[F_MODE +: 2]);
  assign frc_shadow_o = frc_q[2*NUM_CH-1:0];

  always_comb begin
    bus_rdata = '0;
    for (int ch = 0; ch < NUM_CH; ch++)
      if (bus_addr == ADDR_W'(ch)) bus_rdata = tbl_q[ch];
    if (bus_addr == MODE_ADDR) bus_rdata = mode_q;
    if (bus_addr == FRC_ADDR)  bus_rdata = frc_q;
  end

  // R2
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == MODE_ADDR) |=> (mode_o == rld_e'($past(bus_wdata[F_MODE +: 2]))));

  // R2
  frc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == FRC_ADDR) |=> (frc_shadow_o == $past(bus_wdata[2*NUM_CH-1:0])));

endmodule

// File: rtl/pwmaq_force.sv
module pwmaq_force
  import pwmaq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  evt_t                ev_i,
  input  rld_e                mode_i,
  input  logic [2*NUM_CH-1:0] shadow_i,
  output logic [2*NUM_CH-1:0] eff_o
);

  logic [2*NUM_CH-1:0] active_q;
  logic                evt_match;
  logic                reload_now;

  always_comb begin
    unique case (mode_i)
      RLD_ZERO:   evt_match = ev_i.zero;
      RLD_PERIOD: evt_match = ev_i.period;
      RLD_EITHER: evt_match = ev_i.zero | ev_i.period;
      default:    evt_match = 1'b1;
    endcase
  end

  assign reload_now = (mode_i == RLD_NOW) || (tick_i && evt_match);
  assign eff_o      = reload_now ? shadow_i : active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      active_q <= '0;
    else if (reload_now)
      active_q <= shadow_i;
  end

  // R8
  no_reload_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != RLD_NOW && !tick_i) |=> $stable(active_q));

  // R11
  immediate_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == RLD_NOW) |=> (active_q == $past(shadow_i)));

endmodule

// File: rtl/pwmaq_chan.sv
module pwmaq_chan
  import pwmaq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_i,
  input  evt_t     ev_i,
  input  act_tbl_t tbl_i,
  input  logic [1:0] frc_i,
  output logic     pwm_o
);

  logic [NUM_EVT-1:0]      ev_v;
  logic [NUM_EVT-1:0][1:0] tbl_v;
  act_e                    sel;
  logic                    pwm_q;
  logic                    pwm_d;

  assign ev_v  = ev_i;
  assign tbl_v = tbl_i;

  // later index carries higher priority and overwrites earlier winners
  always_comb begin
    sel = ACT_KEEP;
    for (int i = 0; i < NUM_EVT; i++)
      if (ev_v[i] && tbl_v[i] != 2'b00) sel = act_e'(tbl_v[i]);
  end

  always_comb begin
    unique case (frc_i)
      2'b01:   pwm_d = 1'b0;
      2'b10:   pwm_d = 1'b1;
      default: begin
        unique case (sel)
          ACT_LOW:    pwm_d = 1'b0;
          ACT_HIGH:   pwm_d = 1'b1;
          ACT_INVERT: pwm_d = ~pwm_q;
          default:    pwm_d = pwm_q;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pwm_q <= 1'b0;
    else if (tick_i)
      pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;

  // R3
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(pwm_q));

  // R7
  force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && frc_i == 2'b01) |=> !pwm_q);

  // R7
  force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && frc_i == 2'b10) |=> pwm_q);

  // R5
  cmpb_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && frc_i[0] == frc_i[1] && ev_i.cmpb_up && tbl_i.cmpb_up == ACT_HIGH) |=> pwm_q);

  // R4
  invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && frc_i[0] == frc_i[1] && ev_i == 4'b0001 && tbl_i.zero == ACT_INVERT)
      |=> (pwm_q != $past(pwm_q)));

endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import pwmaq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_tick,
  input  logic              ev_zero,
  input  logic              ev_period,
  input  logic              ev_cmpa_up,
  input  logic              ev_cmpb_up,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_a,
  output logic              pwm_b
);

  evt_t                  ev;
  act_tbl_t [NUM_CH-1:0] tbl;
  rld_e                  mode;
  logic [2*NUM_CH-1:0]   frc_shadow;
  logic [2*NUM_CH-1:0]   frc_eff;
  logic [NUM_CH-1:0]     pwm;

  assign ev.zero    = ev_zero;
  assign ev.period  = ev_period;
  assign ev.cmpa_up = ev_cmpa_up;
  assign ev.cmpb_up = ev_cmpb_up;

  pwmaq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .tbl_o        (tbl),
    .mode_o       (mode),
    .frc_shadow_o (frc_shadow)
  );

  pwmaq_force force_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tb_tick),
    .ev_i     (ev),
    .mode_i   (mode),
    .shadow_i (frc_shadow),
    .eff_o    (frc_eff)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pwmaq_chan chan_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tb_tick),
      .ev_i   (ev),
      .tbl_i  (tbl[ch]),
      .frc_i  (frc_eff[2*ch +: 2]),
      .pwm_o  (pwm[ch])
    );
  end

  assign pwm_a = pwm[0];
  assign pwm_b = pwm[1];

endmodule

// File: tb/pwm_action_qual_tb.sv
module pwm_action_qual_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tb_tick = 1'b0;
  logic        ev_zero = 1'b0, ev_period = 1'b0, ev_cmpa_up = 1'b0, ev_cmpb_up = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        pwm_a, pwm_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit started = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int m_tbl [2];
  int m_mode, m_shadow, m_active;
  bit m_out [2];

  always #5 clk = ~clk;

  pwm_action_qual dut_i (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick),
    .ev_zero(ev_zero), .ev_period(ev_period),
    .ev_cmpa_up(ev_cmpa_up), .ev_cmpb_up(ev_cmpb_up),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  function automatic int pick(int tbl, bit z, bit p, bit ca, bit cb);
    int a;
    a = (tbl >> 8) & 3;
    if (cb && a != 0) return a;
    a = (tbl >> 4) & 3;
    if (ca && a != 0) return a;
    a = (tbl >> 2) & 3;
    if (p && a != 0) return a;
    a = tbl & 3;
    if (z && a != 0) return a;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tbl[0] = 0; m_tbl[1] = 0; m_mode = 0; m_shadow = 0; m_active = 0;
      m_out[0] = 0; m_out[1] = 0;
    end else begin
      bit reload;
      int eff;
      reload = (m_mode == 3) ||
               (tb_tick && ((m_mode == 0 && ev_zero) || (m_mode == 1 && ev_period) ||
                            (m_mode == 2 && (ev_zero || ev_period))));
      eff = reload ? m_shadow : m_active;
      if (reload) m_active = m_shadow;
      if (tb_tick) begin
        for (int ch = 0; ch < 2; ch++) begin
          int f, a;
          f = (eff >> (2 * ch)) & 3;
          a = pick(m_tbl[ch], ev_zero, ev_period, ev_cmpa_up, ev_cmpb_up);
          if (f == 1) m_out[ch] = 0;
          else if (f == 2) m_out[ch] = 1;
          else if (a == 1) m_out[ch] = 0;
          else if (a == 2) m_out[ch] = 1;
          else if (a == 3) m_out[ch] = ~m_out[ch];
        end
      end
      if (bus_wr) begin
        case (bus_addr)
          2'd0: m_tbl[0] = bus_wdata & 16'h033F;
          2'd1: m_tbl[1] = bus_wdata & 16'h033F;
          2'd2: m_mode   = (bus_wdata >> 6) & 3;
          default: m_shadow = bus_wdata & 16'h000F;
        endcase
      end
    end
    started = 1'b1;
  end

  function automatic int m_read(logic [1:0] a);
    case (a)
      2'd0: return m_tbl[0];
      2'd1: return m_tbl[1];
      2'd2: return m_mode << 6;
      default: return m_shadow;
    endcase
  endfunction

  // compare against the reference every cycle, away from the edge
  always @(posedge clk) begin
    #3;
    if (started && !done) begin
      checks += 3;
      if (pwm_a !== m_out[0]) begin
        failures++;
        $display("FAIL %s model pwm_a got=%0b exp=%0b t=%0t", cur_req, pwm_a, m_out[0], $time);
      end
      if (pwm_b !== m_out[1]) begin
        failures++;
        $display("FAIL %s model pwm_b got=%0b exp=%0b t=%0t", cur_req, pwm_b, m_out[1], $time);
      end
      if (bus_rdata !== 16'(m_read(bus_addr))) begin
        failures++;
        $display("FAIL %s model rdata got=%h exp=%h t=%0t", cur_req, bus_rdata, 16'(m_read(bus_addr)), $time);
      end
    end
  end

  task automatic chk(logic got, logic exp, string req, string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%0b exp=%0b", req, what, got, exp);
    end
  endtask

  task automatic step(bit t, bit z, bit p, bit ca, bit cb);
    @(negedge clk);
    bus_wr = 0; tb_tick = t; ev_zero = z; ev_period = p; ev_cmpa_up = ca; ev_cmpb_up = cb;
    @(posedge clk); #3;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tb_tick = 0; ev_zero = 0; ev_period = 0; ev_cmpa_up = 0; ev_cmpb_up = 0;
    @(posedge clk); #3;
  endtask

  task automatic rd(logic [1:0] a, logic [15:0] exp, string req);
    @(negedge clk);
    bus_wr = 0; bus_addr = a; tb_tick = 0;
    ev_zero = 0; ev_period = 0; ev_cmpa_up = 0; ev_cmpb_up = 0;
    @(posedge clk); #3;
    checks++;
    if (bus_rdata !== exp) begin
      failures++;
      $display("FAIL %s read addr=%0d got=%h exp=%h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    cur_req = "R1";
    chk(pwm_a, 1'b0, "R1", "reset pwm_a");
    chk(pwm_b, 1'b0, "R1", "reset pwm_b");
    @(negedge clk); rst_n = 1;
    for (int a = 0; a < 4; a++) rd(2'(a), 16'h0000, "R1");

    cur_req = "R2";
    wr(2'd0, 16'hFFFF); rd(2'd0, 16'h033F, "R2");
    wr(2'd1, 16'hA5A5); rd(2'd1, 16'h0125, "R2");
    wr(2'd2, 16'hFFFF); rd(2'd2, 16'h00C0, "R2");
    wr(2'd3, 16'hFFFF); rd(2'd3, 16'h000F, "R2");
    wr(2'd3, 16'h0000); wr(2'd2, 16'h0000);

    // normal PWM on A, inverted on B from a counting time base
    cur_req = "R13";
    wr(2'd0, 16'h001A); wr(2'd1, 16'h0205);
    for (int cyc = 0; cyc < 3; cyc++) begin
      for (int cnt = 0; cnt <= 9; cnt++) begin
        step(1, cnt == 0, cnt == 9, cnt == 3, cnt == 6);
        if (cnt == 0) begin
          chk(pwm_a, 1'b1, "R13", "A at zero");
          chk(pwm_b, 1'b0, "R13", "B at zero");
        end
        if (cnt == 3) chk(pwm_a, 1'b0, "R13", "A at compare");
        if (cnt == 6) chk(pwm_b, 1'b1, "R13", "B at compare");
      end
    end

    cur_req = "R3";
    step(0, 0, 0, 0, 0);
    chk(pwm_b, 1'b0, "R3", "B after period tick then idle");

    cur_req = "R4";
    wr(2'd0, 16'h0003);
    step(1, 1, 0, 0, 0); chk(pwm_a, 1'b0, "R4", "invert 1");
    step(1, 1, 0, 0, 0); chk(pwm_a, 1'b1, "R4", "invert 2");
    wr(2'd0, 16'h0001);
    step(1, 1, 0, 0, 0); chk(pwm_a, 1'b0, "R4", "low code");

    cur_req = "R6";
    wr(2'd0, 16'h0333);
    step(0, 1, 1, 1, 1); chk(pwm_a, 1'b0, "R6", "no tick");
    step(0, 1, 0, 0, 0); chk(pwm_a, 1'b0, "R6", "no tick zero");

    cur_req = "R5";
    wr(2'd0, 16'h0306);
    step(1, 1, 0, 0, 0); chk(pwm_a, 1'b1, "R5", "zero alone");
    step(1, 1, 1, 0, 0); chk(pwm_a, 1'b0, "R5", "period over zero");
    step(1, 1, 1, 0, 1); chk(pwm_a, 1'b1, "R5", "compare B over period");
    step(1, 1, 1, 1, 0); chk(pwm_a, 1'b0, "R5", "keep-coded compare A passed over");

    cur_req = "R8";
    wr(2'd0, 16'h001A);
    step(1, 0, 1, 0, 0); chk(pwm_a, 1'b1, "R8", "preset high");
    wr(2'd3, 16'h0001);
    step(1, 0, 0, 0, 0); chk(pwm_a, 1'b1, "R8", "shadow not yet loaded");
    step(1, 0, 1, 0, 0); chk(pwm_a, 1'b1, "R8", "period does not load");
    step(1, 1, 0, 0, 0); chk(pwm_a, 1'b0, "R8", "loaded at zero");
    cur_req = "R7";
    step(1, 0, 1, 0, 0); chk(pwm_a, 1'b0, "R7", "force beats period high");

    cur_req = "R9";
    wr(2'd2, 16'h0040); wr(2'd3, 16'h0002);
    step(1, 1, 0, 0, 0); chk(pwm_a, 1'b0, "R9", "zero does not load");
    step(1, 0, 1, 0, 0); chk(pwm_a, 1'b1, "R9", "loaded at period");
    step(1, 0, 0, 1, 0); chk(pwm_a, 1'b1, "R7", "force beats compare low");

    cur_req = "R10";
    wr(2'd2, 16'h0080); wr(2'd3, 16'h0001);
    step(1, 0, 0, 1, 0); chk(pwm_a, 1'b1, "R10", "compare does not load");
    step(1, 0, 1, 0, 0); chk(pwm_a, 1'b0, "R10", "loaded at period");
    wr(2'd3, 16'h0002);
    step(1, 1, 0, 0, 0); chk(pwm_a, 1'b1, "R10", "loaded at zero");

    cur_req = "R11";
    wr(2'd2, 16'h00C0); wr(2'd3, 16'h0001);
    chk(pwm_a, 1'b1, "R11", "no change before tick");
    step(1, 0, 0, 0, 0); chk(pwm_a, 1'b0, "R11", "applied on tick");

    cur_req = "R12";
    wr(2'd3, 16'h0000);
    step(1, 0, 0, 0, 0); chk(pwm_a, 1'b0, "R12", "holds after release");
    step(1, 1, 0, 0, 0); chk(pwm_a, 1'b1, "R12", "action after release");

    cur_req = "R7";
    wr(2'd3, 16'h0008);
    step(1, 1, 0, 0, 0); chk(pwm_b, 1'b1, "R7", "B forced high");
    wr(2'd3, 16'h000C);
    step(1, 1, 0, 0, 0); chk(pwm_b, 1'b0, "R7", "code 11 no force");

    cur_req = "R5";
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      bus_wr = ($urandom % 6) == 0;
      bus_addr = 2'($urandom);
      bus_wdata = 16'($urandom);
      tb_tick = ($urandom % 3) != 0;
      ev_zero = ($urandom % 4) == 0;
      ev_period = ($urandom % 4) == 0;
      ev_cmpa_up = ($urandom % 3) == 0;
      ev_cmpb_up = ($urandom % 3) == 0;
    end
    @(negedge clk);
    bus_wr = 0; tb_tick = 0;
    @(posedge clk); #4;
    finish_run();
  end

endmodule